// File: doc/BRIEF.md
# DRAM Address Decoder

This block sits between a bus slave port and a DRAM command scheduler. It turns each incoming byte address into DRAM coordinates: a chip select, a bank, a row and a column. The top byte of the address picks the chip. Each chip has its own base byte and mask byte, and the lower part of the address supplies the bank, row and column fields.

The sizes of the fields are runtime inputs: the number of bank, row and column bits, and the width of the memory data bus. The order of the fields within the address is also a runtime input. In linear order the bank field sits above the row. In interleaved order the bank field sits between the row and the column, so that consecutive rows of the address space rotate across banks.

An address that matches no chip comes out flagged as a miss, with all coordinates zero. The block has one register stage and accepts a new address on every clock.

Top module: `dram_addr_decoder`

## Requirements
- R1: Chip 0 is selected when `(in_addr[31:24] & cfg_mask[7:0]) == (cfg_base[7:0] & cfg_mask[7:0])`. The select is reported as `out_cs = 2'b01`, where bit i stands for chip i.
- R2: Chip 1 uses `cfg_base[15:8]` and `cfg_mask[15:8]` and is reported as `out_cs = 2'b10`. It can only be selected while `cfg_extra_en[0]` is 1, and never while that bit is 0.
- R3: When both chips match, chip 0 wins. A valid, non-miss output always has exactly one bit of `out_cs` set.
- R4: When no enabled chip matches, the output has `out_miss = 1` and `out_cs`, `out_bank`, `out_row` and `out_col` are all zero.
- R5: The byte offset is dropped before decoding. With `cfg_bus32 = 0` (16-bit memory) one low address bit is dropped. With `cfg_bus32 = 1` (32-bit memory) two bits are dropped. The remaining value is called the word address.
- R6: With `cfg_interleave = 0` (linear order), the column is the lowest C bits of the word address, the row is the next R bits and the bank is the next B bits above the row.
- R7: With `cfg_interleave = 1` (interleaved order), the column is the lowest C bits of the word address, the bank is the next B bits and the row is the next R bits above the bank.
- R8: The field widths are set at run time. R comes from `cfg_row_bits` and is clamped to the range 13..15. C comes from `cfg_col_bits` and is clamped to 9..11. B is 3 when `cfg_bank3 = 1` and 2 otherwise. Output bits above the active width of each field are zero.
- R9: An address presented with `in_valid` appears on the outputs one clock later, with `out_valid = 1`. Addresses may arrive on consecutive clocks. A clock with `in_valid = 0` yields `out_valid = 0` with all other outputs zero on the next clock.
- R10: After a synchronous reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Address is present this cycle |
| in_addr | input | 32 | Byte address |
| cfg_base | input | 16 | Base bytes, chip 0 in [7:0], chip 1 in [15:8] |
| cfg_mask | input | 16 | Mask bytes, same layout as cfg_base |
| cfg_extra_en | input | 1 | Enable for chip 1 |
| cfg_row_bits | input | 4 | Row bit count (clamped to 13..15) |
| cfg_col_bits | input | 4 | Column bit count (clamped to 9..11) |
| cfg_bank3 | input | 1 | 1: eight banks, 0: four banks |
| cfg_bus32 | input | 1 | 1: 32-bit memory, 0: 16-bit memory |
| cfg_interleave | input | 1 | 1: bank between row and column |
| out_valid | output | 1 | Registered result valid |
| out_miss | output | 1 | No chip matched |
| out_cs | output | 2 | One-hot chip select |
| out_bank | output | 3 | Bank index |
| out_row | output | 15 | Row index |
| out_col | output | 11 | Column index |

## Verification
A wrong shift amount or mask inside the decoder shows up at the ports exactly one clock after the offending address. It appears as a field that has shifted or grown bits above its configured width, so the bench compares every output against a model computed from the requirements, over every legal combination of widths, bus width and field order. A wrong priority or enable decision shows up on that same clock as a wrong one-hot select or a spurious miss. A stuck pipeline register shows up when back-to-back addresses are followed by an idle clock, because that idle clock must read as all zeros.

// File: rtl/dmap_pkg.sv
package dmap_pkg;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } field_order_e;

  // Normalised field widths, 4-bit counts.
  typedef struct packed {
    logic [3:0] bank_n;
    logic [3:0] row_n;
    logic [3:0] col_n;
    logic [1:0] drop_n;
    field_order_e order;
  } geom_t;

endpackage

// File: rtl/dmap_geom_norm.sv
module dmap_geom_norm #(
  parameter int CNT_W      = 4,
  parameter int ROW_MIN_W  = 13,
  parameter int ROW_MAX_W  = 15,
  parameter int COL_MIN_W  = 9,
  parameter int COL_MAX_W  = 11,
  parameter int BANK_MIN_W = 2,
  parameter int BANK_MAX_W = 3
) (
  input  logic [CNT_W-1:0] row_bits,
  input  logic [CNT_W-1:0] col_bits,
  input  logic             bank3,
  input  logic             bus32,
  input  logic             interleave,
  output dmap_pkg::geom_t  geom
);
  localparam logic [CNT_W-1:0] RMIN = CNT_W'(ROW_MIN_W);
  localparam logic [CNT_W-1:0] RMAX = CNT_W'(ROW_MAX_W);
  localparam logic [CNT_W-1:0] CMIN = CNT_W'(COL_MIN_W);
  localparam logic [CNT_W-1:0] CMAX = CNT_W'(COL_MAX_W);

  always_comb begin
    geom = '0;
    if (row_bits < RMIN)      geom.row_n = 4'(RMIN);
    else if (row_bits > RMAX) geom.row_n = 4'(RMAX);
    else                      geom.row_n = 4'(row_bits);
    if (col_bits < CMIN)      geom.col_n = 4'(CMIN);
    else if (col_bits > CMAX) geom.col_n = 4'(CMAX);
    else                      geom.col_n = 4'(col_bits);
    geom.bank_n = bank3 ? 4'(BANK_MAX_W) : 4'(BANK_MIN_W);
    geom.drop_n = bus32 ? 2'd2 : 2'd1;
    geom.order  = interleave ? dmap_pkg::ORDER_INTERLEAVE : dmap_pkg::ORDER_LINEAR;
  end
endmodule

// File: rtl/dmap_chip_match.sv
module dmap_chip_match #(
  parameter int N_CHIPS = 2,
  parameter int SEL_W   = 8
) (
  input  logic [SEL_W-1:0]         sel,
  input  logic [N_CHIPS*SEL_W-1:0] base,
  input  logic [N_CHIPS*SEL_W-1:0] mask,
  input  logic [N_CHIPS-1:0]       en,
  output logic [N_CHIPS-1:0]       hit,
  output logic [N_CHIPS-1:0]       grant
);
  for (genvar g = 0; g < N_CHIPS; g++) begin : g_cmp
    logic [SEL_W-1:0] m;
    assign m      = mask[g*SEL_W +: SEL_W];
    assign hit[g] = en[g] && ((sel & m) == (base[g*SEL_W +: SEL_W] & m));
  end

  // Lowest index wins.
  always_comb begin
    grant = '0;
    for (int i = N_CHIPS - 1; i >= 0; i--) begin
      if (hit[i]) grant = N_CHIPS'(1) << i;
    end
  end
endmodule

// File: rtl/dmap_field_split.sv
module dmap_field_split #(
  parameter int ADDR_W     = 32,
  parameter int ROW_MAX_W  = 15,
  parameter int COL_MAX_W  = 11,
  parameter int BANK_MAX_W = 3
) (
  input  logic [ADDR_W-1:0]     addr,
  input  dmap_pkg::geom_t       geom,
  output logic [BANK_MAX_W-1:0] bank,
  output logic [ROW_MAX_W-1:0]  row,
  output logic [COL_MAX_W-1:0]  col
);
  localparam int SH_W = 6;

  logic [ADDR_W-1:0]     word;
  logic [ADDR_W-1:0]     row_src, bank_src;
  logic [SH_W-1:0]       row_sh, bank_sh;
  logic [COL_MAX_W-1:0]  col_m;
  logic [ROW_MAX_W-1:0]  row_m;
  logic [BANK_MAX_W-1:0] bank_m;

  always_comb begin
    word   = addr >> geom.drop_n;
    col_m  = ~({COL_MAX_W{1'b1}} << geom.col_n);
    row_m  = ~({ROW_MAX_W{1'b1}} << geom.row_n);
    bank_m = ~({BANK_MAX_W{1'b1}} << geom.bank_n);
    if (geom.order == dmap_pkg::ORDER_INTERLEAVE) begin
      bank_sh = SH_W'(geom.col_n);
      row_sh  = SH_W'(geom.col_n) + SH_W'(geom.bank_n);
    end else begin
      row_sh  = SH_W'(geom.col_n);
      bank_sh = SH_W'(geom.col_n) + SH_W'(geom.row_n);
    end
    row_src  = word >> row_sh;
    bank_src = word >> bank_sh;
    col  = word[COL_MAX_W-1:0] & col_m;
    row  = row_src[ROW_MAX_W-1:0] & row_m;
    bank = bank_src[BANK_MAX_W-1:0] & bank_m;
  end
endmodule

// File: rtl/dram_addr_decoder.sv
module dram_addr_decoder #(
  parameter int ADDR_W     = 32,
  parameter int SEL_W      = 8,
  parameter int N_CHIPS    = 2,
  parameter int CNT_W      = 4,
  parameter int ROW_MIN_W  = 13,
  parameter int ROW_MAX_W  = 15,
  parameter int COL_MIN_W  = 9,
  parameter int COL_MAX_W  = 11,
  parameter int BANK_MIN_W = 2,
  parameter int BANK_MAX_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [ADDR_W-1:0]        in_addr,
  input  logic [N_CHIPS*SEL_W-1:0] cfg_base,
  input  logic [N_CHIPS*SEL_W-1:0] cfg_mask,
  input  logic [N_CHIPS-2:0]       cfg_extra_en,
  input  logic [CNT_W-1:0]         cfg_row_bits,
  input  logic [CNT_W-1:0]         cfg_col_bits,
  input  logic                     cfg_bank3,
  input  logic                     cfg_bus32,
  input  logic                     cfg_interleave,
  output logic                     out_valid,
  output logic                     out_miss,
  output logic [N_CHIPS-1:0]       out_cs,
  output logic [BANK_MAX_W-1:0]    out_bank,
  output logic [ROW_MAX_W-1:0]     out_row,
  output logic [COL_MAX_W-1:0]     out_col
);
  localparam int SEL_LSB = ADDR_W - SEL_W;

  dmap_pkg::geom_t       geom;
  logic [N_CHIPS-1:0]    chip_en, hit, grant;
  logic [BANK_MAX_W-1:0] bank_c;
  logic [ROW_MAX_W-1:0]  row_c;
  logic [COL_MAX_W-1:0]  col_c;
  logic                  any_hit;

  dmap_geom_norm #(
    .CNT_W(CNT_W), .ROW_MIN_W(ROW_MIN_W), .ROW_MAX_W(ROW_MAX_W),
    .COL_MIN_W(COL_MIN_W), .COL_MAX_W(COL_MAX_W),
    .BANK_MIN_W(BANK_MIN_W), .BANK_MAX_W(BANK_MAX_W)
  ) u_norm (
    .row_bits(cfg_row_bits), .col_bits(cfg_col_bits), .bank3(cfg_bank3),
    .bus32(cfg_bus32), .interleave(cfg_interleave), .geom(geom)
  );

  assign chip_en = {cfg_extra_en, 1'b1};

  dmap_chip_match #(.N_CHIPS(N_CHIPS), .SEL_W(SEL_W)) u_match (
    .sel(in_addr[ADDR_W-1:SEL_LSB]), .base(cfg_base), .mask(cfg_mask),
    .en(chip_en), .hit(hit), .grant(grant)
  );

  // R2
  chip1_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !chip_en[1] |-> !grant[1]);

  dmap_field_split #(
    .ADDR_W(ADDR_W), .ROW_MAX_W(ROW_MAX_W), .COL_MAX_W(COL_MAX_W),
    .BANK_MAX_W(BANK_MAX_W)
  ) u_split (
    .addr(in_addr), .geom(geom), .bank(bank_c), .row(row_c), .col(col_c)
  );

  assign any_hit = |hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_miss  <= 1'b0;
      out_cs    <= '0;
      out_bank  <= '0;
      out_row   <= '0;
      out_col   <= '0;
    end else begin
      out_valid <= in_valid;
      out_miss  <= in_valid && !any_hit;
      if (in_valid && any_hit) begin
        out_cs   <= grant;
        out_bank <= bank_c;
        out_row  <= row_c;
        out_col  <= col_c;
      end else begin
        out_cs   <= '0;
        out_bank <= '0;
        out_row  <= '0;
        out_col  <= '0;
      end
    end
  end

  // R9
  accept_lat_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_miss && out_cs == '0 && out_row == '0));
  // R4
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_miss |-> (out_cs == '0 && out_bank == '0 && out_row == '0 && out_col == '0));
  // R3
  cs_single_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_miss) |-> ($countones(out_cs) == 1));
  // R3
  cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_cs));
endmodule

// File: tb/tb_dram_addr_decoder.sv
module tb_dram_addr_decoder;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] in_addr;
  logic [15:0] cfg_base, cfg_mask;
  logic [0:0]  cfg_extra_en;
  logic [3:0]  cfg_row_bits, cfg_col_bits;
  logic        cfg_bank3, cfg_bus32, cfg_interleave;
  logic        out_valid, out_miss;
  logic [1:0]  out_cs;
  logic [2:0]  out_bank;
  logic [14:0] out_row;
  logic [10:0] out_col;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dram_addr_decoder dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
    .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_extra_en(cfg_extra_en),
    .cfg_row_bits(cfg_row_bits), .cfg_col_bits(cfg_col_bits),
    .cfg_bank3(cfg_bank3), .cfg_bus32(cfg_bus32), .cfg_interleave(cfg_interleave),
    .out_valid(out_valid), .out_miss(out_miss), .out_cs(out_cs),
    .out_bank(out_bank), .out_row(out_row), .out_col(out_col)
  );

  // {valid, miss, cs[1:0], bank[2:0], row[14:0], col[10:0]} = 33 bits
  function automatic logic [32:0] model(input logic v, input logic [31:0] a);
    int r, c, b;
    logic [31:0] w;
    logic [7:0] top;
    logic h0, h1;
    logic [1:0] cs;
    logic [14:0] row;
    logic [10:0] col;
    logic [2:0] bank;
    if (!v) return '0;
    r = (cfg_row_bits < 13) ? 13 : (cfg_row_bits > 15) ? 15 : int'(cfg_row_bits);
    c = (cfg_col_bits < 9) ? 9 : (cfg_col_bits > 11) ? 11 : int'(cfg_col_bits);
    b = cfg_bank3 ? 3 : 2;
    top = a[31:24];
    h0 = (top & cfg_mask[7:0]) == (cfg_base[7:0] & cfg_mask[7:0]);
    h1 = cfg_extra_en[0] && ((top & cfg_mask[15:8]) == (cfg_base[15:8] & cfg_mask[15:8]));
    if (!h0 && !h1) return {1'b1, 1'b1, 31'd0};
    cs = h0 ? 2'b01 : 2'b10;
    w = cfg_bus32 ? (a / 4) : (a / 2);
    col = 11'(w % (32'd1 << c));
    if (cfg_interleave) begin
      bank = 3'((w >> c) % (32'd1 << b));
      row  = 15'((w >> (c + b)) % (32'd1 << r));
    end else begin
      row  = 15'((w >> c) % (32'd1 << r));
      bank = 3'((w >> (c + r)) % (32'd1 << b));
    end
    return {1'b1, 1'b0, cs, bank, row, col};
  endfunction

  task automatic compare(input string req, input logic [32:0] exp);
    logic [32:0] act;
    act = {out_valid, out_miss, out_cs, out_bank, out_row, out_col};
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive on falling edge, sample 2 ns after the next rising edge.
  task automatic send(input string req, input logic v, input logic [31:0] a);
    logic [32:0] exp;
    @(negedge clk);
    in_valid = v;
    in_addr  = a;
    exp = model(v, a);
    @(posedge clk);
    #2;
    compare(req, exp);
  endtask

  task automatic set_default();
    cfg_base = 16'h80_40; cfg_mask = 16'hC0_C0; cfg_extra_en = 1'b0;
    cfg_row_bits = 4'd13; cfg_col_bits = 4'd10; cfg_bank3 = 1'b0;
    cfg_bus32 = 1'b1; cfg_interleave = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1; in_valid = 1'b1; in_addr = 32'h4123_4567;
    @(posedge clk); #2;
    compare("R10 reset", '0);
    @(negedge clk); rst = 1'b0; in_valid = 1'b0;
  endtask

  task automatic t_chip0();
    send("R1 chip0 low edge", 1'b1, 32'h4000_0000);
    send("R1 chip0 high edge", 1'b1, 32'h7FFF_FFFC);
    send("R1 chip0 mid", 1'b1, 32'h5A5A_A5A4);
    send("R4 below chip0", 1'b1, 32'h3FFF_FFFF);
  endtask

  task automatic t_chip1();
    cfg_extra_en = 1'b0;
    send("R2 chip1 disabled", 1'b1, 32'h8123_4560);
    cfg_extra_en = 1'b1;
    send("R2 chip1 enabled", 1'b1, 32'h8123_4560);
    send("R2 chip1 top", 1'b1, 32'hBFFF_FFF0);
    send("R4 miss both enabled", 1'b1, 32'hC000_1000);
    send("R4 miss zero page", 1'b1, 32'h0000_0000);
    cfg_extra_en = 1'b0;
  endtask

  task automatic t_priority();
    cfg_extra_en = 1'b1; cfg_mask = 16'h00_C0;
    send("R3 both match chip0 wins", 1'b1, 32'h4444_4444);
    send("R3 only chip1", 1'b1, 32'h0444_4444);
    cfg_extra_en = 1'b0;
    send("R2 catch-all disabled", 1'b1, 32'h0444_4444);
    set_default();
  endtask

  task automatic t_sweep();
    for (int r = 13; r <= 15; r++)
      for (int c = 9; c <= 11; c++)
        for (int k = 0; k < 8; k++) begin
          cfg_row_bits = 4'(r); cfg_col_bits = 4'(c);
          cfg_bank3 = k[0]; cfg_bus32 = k[1]; cfg_interleave = k[2];
          send(k[2] ? "R7 interleave sweep" : "R6 linear sweep", 1'b1, 32'h7B6D_5E3C ^ 32'(r * 97 + c * 13 + k));
          send(k[1] ? "R5 bus32 sweep" : "R5 bus16 sweep", 1'b1, 32'h4FFF_FFFF);
          send("R8 width sweep", 1'b1, 32'h4000_0001 + 32'(1 << (c + 1)));
        end
    set_default();
  endtask

  task automatic t_fields_direct();
    logic [32:0] e;
    // Linear, C=10 R=13 B=2, 32-bit: word=addr>>2.
    // word bits: col[9:0], row[22:10], bank[24:23].
    @(negedge clk); in_valid = 1'b1;
    in_addr = 32'h4000_0000 | (32'd2 << 25) | (32'd5 << 12) | (32'd3 << 2);
    @(posedge clk); #2;
    e = {1'b1, 1'b0, 2'b01, 3'd2, 15'd5, 11'd3};
    compare("R6 linear direct", e);
    cfg_interleave = 1'b1;
    // word bits: col[9:0], bank[11:10], row[24:12].
    @(negedge clk);
    in_addr = 32'h4000_0000 | (32'd9 << 14) | (32'd1 << 12) | (32'd7 << 2);
    @(posedge clk); #2;
    e = {1'b1, 1'b0, 2'b01, 3'd1, 15'd9, 11'd7};
    compare("R7 interleave direct", e);
    cfg_bus32 = 1'b0; cfg_interleave = 1'b0;
    // 16-bit: word=addr>>1, col = addr[10:1].
    @(negedge clk); in_addr = 32'h4000_0006;
    @(posedge clk); #2;
    e = {1'b1, 1'b0, 2'b01, 3'd0, 15'd0, 11'd3};
    compare("R5 bus16 direct", e);
    set_default();
  endtask

  task automatic t_clamp();
    cfg_row_bits = 4'd2;  cfg_col_bits = 4'd3;
    send("R8 clamp low", 1'b1, 32'h7FFF_FFFF);
    cfg_row_bits = 4'hF; cfg_col_bits = 4'hE;
    send("R8 clamp high cols", 1'b1, 32'h7FFF_FFFF);
    cfg_row_bits = 4'd0; cfg_col_bits = 4'hF; cfg_interleave = 1'b1; cfg_bank3 = 1'b1;
    send("R8 clamp interleave", 1'b1, 32'h6DB6_DB6C);
    set_default();
  endtask

  task automatic t_stream();
    for (int i = 0; i < 24; i++)
      send("R9 back-to-back", 1'b1, 32'h4000_0000 + 32'(i * 32'h0013_5793));
    send("R9 idle after stream", 1'b0, 32'h4FFF_FFFF);
    send("R9 resume", 1'b1, 32'h4ABC_DEF0);
    send("R9 idle miss address", 1'b0, 32'h0000_0000);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_addr = '0;
    set_default();
    repeat (3) @(posedge clk);
    t_reset();
    t_chip0();
    t_chip1();
    t_priority();
    t_fields_direct();
    t_clamp();
    t_sweep();
    t_stream();
    @(negedge clk); in_valid = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule